// File: doc/BRIEF.md
# USB IN Endpoint NAK Flag Controller

This block decides the handshake for IN tokens on five transmit endpoints. Each endpoint has a ready bit. Firmware sets that bit by writing the endpoint's transmit size register, which the block sees as a one-cycle strobe carrying the endpoint number. When the serial engine presents an IN token, the block answers one cycle later with ACK if the endpoint is ready, or NAK if it is not. An ACK means the loaded packet has been handed off, so the endpoint drops back to not ready at the same clock edge.

Each NAK caused by an empty endpoint raises a sticky per-endpoint flag. Firmware reads the flags as a byte. It clears a flag by writing a 0 to that flag's bit, and writing a 1 leaves the bit alone. An interrupt line is high while any active flag is set.

A pairing input couples endpoints in twos. In paired mode only the odd-numbered flags are active: NAKs to even-numbered endpoints are still sent, but they raise no flag, and even-numbered flags take no part in the interrupt.

Top module: `usb_in_nak_ctrl`

## Requirements
- R1: After reset the status byte reads 00h, `irq` is 0, no response pulse is given, and every endpoint is not ready.
- R2: In the status byte, bit n (n = 0..4) is the flag of endpoint n. Bits 7..5 always read 0.
- R3: An IN token to endpoint n in 0..4 gives exactly one response one cycle later: `respNak` if n was not ready, otherwise `respAck`. The two are never high together.
- R4: A NAK to endpoint n sets flag n. The flag is visible in the cycle after the token and stays set until firmware clears it.
- R5: A size-register write strobe for endpoint n makes n ready, and the next token to n is answered with `respAck`.
- R6: An ACK returns the endpoint to not ready, so a following token to it gets a NAK.
- R7: A flag write clears every flag whose bit in `flagWrData` is 0.
- R8: A 1 in `flagWrData` leaves that flag unchanged. Writes to bits 7..5 are ignored.
- R9: A token whose endpoint number is 5, 6 or 7 gives no response and sets no flag.
- R10: With `pairMode` = 1, a NAK to an even-numbered endpoint (0, 2, 4) is still sent but sets no flag. Odd-numbered flags are set as usual.
- R11: When a NAK set and a firmware clear hit the same flag in the same cycle, the flag ends up set.
- R12: `irq` is 1 exactly when an active flag is 1. All five flags are active with `pairMode` = 0; only flags 1 and 3 are active with `pairMode` = 1.
- R13: When a size write and a token hit the same endpoint in the same cycle, the token sees the earlier state (NAK if it was not ready), and the endpoint is ready afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pairMode | input | 1 | 1 = endpoints paired; only odd flags are active |
| tokValid | input | 1 | IN token strobe from the serial engine |
| tokEp | input | 3 | Endpoint number of the token |
| sizeWr | input | 1 | Transmit size register write strobe |
| sizeEp | input | 3 | Endpoint number of the size write |
| flagWr | input | 1 | Write strobe for the flag register |
| flagWrData | input | 8 | Write data; a 0 bit clears that flag |
| respAck | output | 1 | ACK pulse, one cycle after the token |
| respNak | output | 1 | NAK pulse, one cycle after the token |
| flagStatus | output | 8 | Flag register read value |
| irq | output | 1 | Interrupt: an active flag is set |

## Verification
The bench goes after these cases:

- **Set and clear in the same cycle.** A design that lets the clear win would drop the bit and lose a NAK event.
- **Arm and token in the same cycle.** A design that forwards the write would ACK a packet that was never there.
- **Token to an endpoint that was just ACKed.** A design that keeps the endpoint ready after an ACK would ACK again instead of NAKing.
- **Paired mode.** The bench NAKs even-numbered endpoints and checks that no flag rises. It also keeps an even flag that was set before the mode changed, and checks that this flag does not drive `irq`.
- **Flag writes.** Writes of all ones and writes with the reserved bits set must change nothing, where a design that treats 1 as clear would wipe the register.
- **Bad endpoint numbers.** Tokens to numbers 5 to 7 must stay silent, where a loose decoder would alias them onto real endpoints.

// File: rtl/usb_nak_pkg.sv
package usb_nak_pkg;
  localparam int NUM_IN_EP = 5;
  localparam int STAT_W    = 8;
  localparam int EP_W      = 3;
  localparam int RSV_W     = STAT_W - NUM_IN_EP;

  // Strobes from the control module to the datapath, one bit per endpoint.
  typedef struct packed {
    logic [NUM_IN_EP-1:0] arm;       // size register written: becomes ready
    logic [NUM_IN_EP-1:0] clrReady;  // packet handed off on ACK
    logic [NUM_IN_EP-1:0] setFlag;   // NAK event, already masked for pairing
    logic [NUM_IN_EP-1:0] fwClr;     // firmware wrote 0 to this flag bit
  } dpStrobes_t;
endpackage

// File: rtl/usb_nak_ctrl.sv
module usb_nak_ctrl
  import usb_nak_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pairMode,
  input  logic                 tokValid,
  input  logic [EP_W-1:0]      tokEp,
  input  logic                 sizeWr,
  input  logic [EP_W-1:0]      sizeEp,
  input  logic                 flagWr,
  input  logic [STAT_W-1:0]    flagWrData,
  input  logic [NUM_IN_EP-1:0] readyQ,
  output dpStrobes_t           strb,
  output logic                 respAck,
  output logic                 respNak
);
  logic [NUM_IN_EP-1:0] tokSel;
  logic [NUM_IN_EP-1:0] armSel;
  logic [NUM_IN_EP-1:0] setMask;

  // Decode endpoint numbers. Numbers past the last endpoint match nothing.
  for (genvar i = 0; i < NUM_IN_EP; i++) begin : g_dec
    assign tokSel[i] = tokValid && (tokEp == EP_W'(i));
    assign armSel[i] = sizeWr && (sizeEp == EP_W'(i));
    if (i % 2 == 1) begin : g_odd
      assign setMask[i] = 1'b1;
    end else begin : g_even
      assign setMask[i] = !pairMode;
    end
  end

  always_comb begin
    strb.arm      = armSel;
    strb.clrReady = tokSel & readyQ;
    strb.setFlag  = tokSel & ~readyQ & setMask;
    strb.fwClr    = flagWr ? ~flagWrData[NUM_IN_EP-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respAck <= 1'b0;
      respNak <= 1'b0;
    end else begin
      respAck <= |(tokSel & readyQ);
      respNak <= |(tokSel & ~readyQ);
    end
  end
endmodule

// File: rtl/usb_nak_dp.sv
module usb_nak_dp
  import usb_nak_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pairMode,
  input  dpStrobes_t           strb,
  output logic [NUM_IN_EP-1:0] readyQ,
  output logic [STAT_W-1:0]    statusByte,
  output logic                 irq
);
  logic [NUM_IN_EP-1:0] flagQ;
  logic [NUM_IN_EP-1:0] activeMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ <= '0;
      flagQ  <= '0;
    end else begin
      // A size write beats the hand-off. A NAK set beats a firmware clear.
      readyQ <= (readyQ & ~strb.clrReady) | strb.arm;
      flagQ  <= (flagQ & ~strb.fwClr) | strb.setFlag;
    end
  end

  for (genvar i = 0; i < NUM_IN_EP; i++) begin : g_act
    if (i % 2 == 1) begin : g_odd
      assign activeMask[i] = 1'b1;
    end else begin : g_even
      assign activeMask[i] = !pairMode;
    end
  end

  assign statusByte = {{RSV_W{1'b0}}, flagQ};
  assign irq        = |(flagQ & activeMask);
endmodule

// File: rtl/usb_in_nak_ctrl.sv
module usb_in_nak_ctrl
  import usb_nak_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pairMode,
  input  logic              tokValid,
  input  logic [EP_W-1:0]   tokEp,
  input  logic              sizeWr,
  input  logic [EP_W-1:0]   sizeEp,
  input  logic              flagWr,
  input  logic [STAT_W-1:0] flagWrData,
  output logic              respAck,
  output logic              respNak,
  output logic [STAT_W-1:0] flagStatus,
  output logic              irq
);
  dpStrobes_t           strb;
  logic [NUM_IN_EP-1:0] readyQ;

  usb_nak_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .pairMode(pairMode),
    .tokValid(tokValid), .tokEp(tokEp),
    .sizeWr(sizeWr), .sizeEp(sizeEp),
    .flagWr(flagWr), .flagWrData(flagWrData),
    .readyQ(readyQ), .strb(strb),
    .respAck(respAck), .respNak(respNak)
  );

  usb_nak_dp dp_i (
    .clk(clk), .rstN(rstN), .pairMode(pairMode),
    .strb(strb), .readyQ(readyQ),
    .statusByte(flagStatus), .irq(irq)
  );
endmodule

// File: rtl/usb_nak_chk.sv
module usb_nak_chk
  import usb_nak_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              pairMode,
  input logic              tokValid,
  input logic [EP_W-1:0]   tokEp,
  input logic              flagWr,
  input logic [STAT_W-1:0] flagWrData,
  input logic              respAck,
  input logic              respNak,
  input logic [STAT_W-1:0] flagStatus,
  input logic              irq
);
  logic                 tokHit;
  logic                 tokBad;
  logic [NUM_IN_EP-1:0] keepMask;

  assign tokHit   = tokValid && ({1'b0, tokEp} < (EP_W+1)'(NUM_IN_EP));
  assign tokBad   = tokValid && !tokHit;
  assign keepMask = flagStatus[NUM_IN_EP-1:0] &
                    (flagWr ? flagWrData[NUM_IN_EP-1:0] : {NUM_IN_EP{1'b1}});

  a_r3_one_resp: assert property (@(posedge clk) disable iff (!rstN)
    !(respAck && respNak));

  a_r3_token_answered: assert property (@(posedge clk) disable iff (!rstN)
    tokHit |=> (respAck || respNak));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    flagStatus[STAT_W-1:NUM_IN_EP] == '0);

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (keepMask != '0) |=>
      ((flagStatus[NUM_IN_EP-1:0] & $past(keepMask)) == $past(keepMask)));

  a_r9_bad_ep_silent: assert property (@(posedge clk) disable iff (!rstN)
    tokBad |=> (!respAck && !respNak));

  a_r10_even_masked: assert property (@(posedge clk) disable iff (!rstN)
    (pairMode && tokHit && !tokEp[0] && !flagStatus[tokEp] && !flagWr) |=>
      !flagStatus[$past(tokEp)]);

  a_r12_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (flagStatus == '0) |-> !irq);
endmodule

bind usb_in_nak_ctrl usb_nak_chk chk_i (
  .clk(clk), .rstN(rstN), .pairMode(pairMode),
  .tokValid(tokValid), .tokEp(tokEp),
  .flagWr(flagWr), .flagWrData(flagWrData),
  .respAck(respAck), .respNak(respNak),
  .flagStatus(flagStatus), .irq(irq)
);

// File: tb/usb_in_nak_ctrl_tb.sv
module usb_in_nak_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic       pairMode, tokValid, sizeWr, flagWr;
  logic [2:0] tokEp, sizeEp;
  logic [7:0] flagWrData;
  logic       respAck, respNak, irq;
  logic [7:0] flagStatus;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  usb_in_nak_ctrl dut_i (
    .clk(clk), .rstN(rstN), .pairMode(pairMode),
    .tokValid(tokValid), .tokEp(tokEp),
    .sizeWr(sizeWr), .sizeEp(sizeEp),
    .flagWr(flagWr), .flagWrData(flagWrData),
    .respAck(respAck), .respNak(respNak),
    .flagStatus(flagStatus), .irq(irq)
  );

  typedef struct packed {
    logic       pair;
    logic       tv;
    logic [2:0] te;
    logic       sw;
    logic [2:0] se;
    logic       fw;
    logic [7:0] fd;
    logic       eAck;
    logic       eNak;
    logic [7:0] eStat;
    logic       eIrq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,3'd2,1'b0,3'd0,1'b0,8'h00, 1'b0,1'b1,8'h04,1'b1}, // R4
    '{1'b0,1'b1,3'd0,1'b0,3'd0,1'b0,8'h00, 1'b0,1'b1,8'h05,1'b1}, // R3
    '{1'b0,1'b0,3'd0,1'b1,3'd2,1'b0,8'h00, 1'b0,1'b0,8'h05,1'b1}, // R5 arm
    '{1'b0,1'b1,3'd2,1'b0,3'd0,1'b0,8'h00, 1'b1,1'b0,8'h05,1'b1}, // R5 ack
    '{1'b0,1'b1,3'd2,1'b0,3'd0,1'b0,8'h00, 1'b0,1'b1,8'h05,1'b1}, // R6
    '{1'b0,1'b0,3'd0,1'b0,3'd0,1'b1,8'hFE, 1'b0,1'b0,8'h04,1'b1}, // R7
    '{1'b0,1'b0,3'd0,1'b0,3'd0,1'b1,8'hFF, 1'b0,1'b0,8'h04,1'b1}, // R8
    '{1'b0,1'b0,3'd0,1'b0,3'd0,1'b1,8'h00, 1'b0,1'b0,8'h00,1'b0}, // R7
    '{1'b0,1'b1,3'd5,1'b0,3'd0,1'b0,8'h00, 1'b0,1'b0,8'h00,1'b0}, // R9
    '{1'b1,1'b1,3'd2,1'b0,3'd0,1'b0,8'h00, 1'b0,1'b1,8'h00,1'b0}, // R10
    '{1'b1,1'b1,3'd3,1'b0,3'd0,1'b0,8'h00, 1'b0,1'b1,8'h08,1'b1}, // R10
    '{1'b1,1'b1,3'd4,1'b0,3'd0,1'b0,8'h00, 1'b0,1'b1,8'h08,1'b1}, // R10
    '{1'b0,1'b1,3'd1,1'b0,3'd0,1'b1,8'h00, 1'b0,1'b1,8'h02,1'b1}, // R11
    '{1'b0,1'b0,3'd0,1'b0,3'd0,1'b1,8'hE0, 1'b0,1'b0,8'h00,1'b0}, // R2
    '{1'b0,1'b1,3'd4,1'b1,3'd4,1'b0,8'h00, 1'b0,1'b1,8'h10,1'b1}, // R13
    '{1'b0,1'b1,3'd4,1'b0,3'd0,1'b0,8'h00, 1'b1,1'b0,8'h10,1'b1}, // R13
    '{1'b0,1'b0,3'd0,1'b0,3'd0,1'b1,8'h00, 1'b0,1'b0,8'h00,1'b0}, // R7
    '{1'b0,1'b1,3'd0,1'b0,3'd0,1'b0,8'h00, 1'b0,1'b1,8'h01,1'b1}, // R12
    '{1'b1,1'b0,3'd0,1'b0,3'd0,1'b0,8'h00, 1'b0,1'b0,8'h01,1'b0}  // R12
  };
  localparam string TAGS [NV] = '{
    "R4", "R3", "R5", "R5", "R6", "R7", "R8", "R7", "R9", "R10",
    "R10", "R10", "R11", "R2", "R13", "R13", "R7", "R12", "R12"};

  task automatic check(input string tag, input logic [10:0] got,
                       input logic [10:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: {ack,nak,stat,irq} got %03h expected %03h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic pr, input logic tv, input logic [2:0] te,
                       input logic sw, input logic [2:0] se,
                       input logic fw, input logic [7:0] fd);
    pairMode = pr; tokValid = tv; tokEp = te;
    sizeWr = sw; sizeEp = se; flagWr = fw; flagWrData = fd;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 8'h00);
    repeat (3) @(negedge clk);
    // r1_: reset state
    check("R1", {respAck, respNak, flagStatus, irq}, 11'h000);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].pair, VECS[i].tv, VECS[i].te, VECS[i].sw, VECS[i].se,
            VECS[i].fw, VECS[i].fd);
      @(negedge clk);
      check(TAGS[i], {respAck, respNak, flagStatus, irq},
            {VECS[i].eAck, VECS[i].eNak, VECS[i].eStat, VECS[i].eIrq});
    end

    // R1: a reset mid-run drops the ready state and the flags
    drive(0, 0, 0, 1, 3'd1, 0, 8'h00);
    @(negedge clk);
    drive(0, 0, 0, 0, 0, 0, 8'h00);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", {respAck, respNak, flagStatus, irq}, 11'h000);
    rstN = 1'b1;
    drive(0, 1, 3'd1, 0, 0, 0, 8'h00);
    @(negedge clk);
    check("R1", {respAck, respNak, flagStatus, irq}, {1'b0, 1'b1, 8'h02, 1'b1});

    // R9: endpoint 7 stays silent
    drive(0, 1, 3'd7, 0, 0, 0, 8'h00);
    @(negedge clk);
    check("R9", {respAck, respNak, flagStatus, irq}, {1'b0, 1'b0, 8'h02, 1'b1});

    // R3: the response is a one-cycle pulse
    drive(0, 0, 0, 0, 0, 0, 8'h00);
    @(negedge clk);
    check("R3", {respAck, respNak, flagStatus, irq}, {1'b0, 1'b0, 8'h02, 1'b1});

    // R12: flag 1 stays active in paired mode
    drive(1, 0, 0, 0, 0, 0, 8'h00);
    @(negedge clk);
    check("R12", {respAck, respNak, flagStatus, irq}, {1'b0, 1'b0, 8'h02, 1'b1});

    finishRun();
  end
endmodule